// File: doc/BRIEF.md
# Scan-Mode Result Buffer Sequencer

This block is the digital back end of a multichannel converter that runs a scan. A configuration write sets how many channels to convert and starts the scan. The block then asks a converter core for one conversion at a time, on channels 0, 1, 2 and so on. Each result the core returns is stored in an internal buffer. While the scan runs, the end-of-conversion flag stays high, the internal conversion clock is enabled and the serial data line stays quiet.

When the final conversion of the scan has been stored, two things happen on the same edge. The end-of-conversion flag drops and the conversion-clock enable turns off. From that moment the serial line already carries the most significant bit of the first result. Each later falling edge of the external serial clock moves the line to the next bit. The results leave MSB first, in the order the channels were converted. After the last bit of the last result, the line holds zero. The flag stays low until the next configuration write starts a new scan.

The analog core is stubbed by a request/done/data handshake. The external serial clock is taken as a level that is already synchronous to the system clock. A falling edge counts when the clock was sampled high on one system clock edge and low on the next.

Top module: `scan_result_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `eoc` is 1, `osc_en` is 0, `conv_req` is 0 and `dout` is 0.
- R2: A `cfg_wr` pulse while no scan is running starts a scan. In the next cycle `eoc` is 1, `osc_en` is 1, `conv_req` is 1 and `conv_chan` is 0. The number of conversions is set by `cfg_scan` (configuration bits 4:3): 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R3: Each `conv_done` pulse during a scan stores `conv_data` and advances `conv_chan` by one. `conv_req` drops once the last conversion of the scan is stored.
- R4: `eoc` and `osc_en` both go low in the cycle after the final `conv_done` of the scan, and never earlier.
- R5: In the first cycle that `eoc` is low, `dout` carries bit 15 of the first channel's result.
- R6: Each falling edge of `sclk` moves `dout` to the next bit. The results appear in channel order, each MSB first.
- R7: After the last bit of the last result, `dout` is 0 on every further `sclk` fall, and `eoc` stays low.
- R8: While `eoc` is high, `dout` is 0 and `sclk` falls do not advance the readout. This includes a fall in the same cycle as the final `conv_done`.
- R9: A `cfg_wr` pulse during a scan is ignored. The channel sequence and the conversion count continue unchanged.
- R10: A `cfg_wr` pulse after a scan has completed, even part-way through the readout, starts a new scan. `eoc` returns high, and only the new results are shifted out afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe; starts a scan |
| cfg_scan | input | 2 | Scan-length field (configuration bits 4:3) |
| conv_req | output | 1 | Conversion request to the converter core |
| conv_chan | output | 3 | Channel being converted |
| conv_done | input | 1 | One-cycle pulse from the core: result valid |
| conv_data | input | 16 | Conversion result from the core |
| osc_en | output | 1 | Internal conversion-clock enable |
| eoc | output | 1 | End-of-conversion flag; low when results are ready |
| sclk | input | 1 | External serial clock, synchronous level |
| dout | output | 1 | Serial result data, MSB first |

## Verification
Two events can arrive in the same system clock cycle: the final `conv_done` of a scan and a falling edge of `sclk`. The design must treat that cycle as the end of the scan only, so the fall must not consume the first result's MSB. The bench raises `sclk` one cycle before the last done pulse and drops it together with that pulse. It then requires that `dout` shows bit 15 of the first result, and that the full readout of every word still matches, starting from its MSB. A second collision is a configuration write that lands mid-readout. That write must win over the remaining shift, with `eoc` rising and the new scan's data replacing the old.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    // Sequencer phases: idle after reset, converting, results ready for readout
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_READY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/scan_ctrl.sv
// scan_ctrl: owns the scan phase, the write pointer into the result buffer,
// the end-of-conversion flag and the conversion-clock enable.
// Assumes conv_done is a one-cycle pulse and is only meaningful while
// conv_req is high; pulses at other times are dropped.
module scan_ctrl
    import scan_seq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_scan,
    input  logic             conv_done,
    output seq_state_t       state,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] last_idx,
    output logic             wr_en,
    output logic             eoc,
    output logic             osc_en
);

    // Map the 2-bit scan field to the index of the final channel (1,2,4,8 channels)
    function automatic logic [PTR_W-1:0] field_to_last(input logic [1:0] f);
        int n;
        n = 1 << f;
        if (n > DEPTH) n = DEPTH;
        return PTR_W'(n - 1);
    endfunction

    // A result is stored on every done pulse seen while converting
    assign wr_en = (state == ST_CONV) && conv_done;

    // Phase sequencing, pointer stepping and flag updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wr_ptr   <= '0;
            last_idx <= '0;
            eoc      <= 1'b1;
            osc_en   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_READY: begin
                    if (cfg_wr) begin
                        state    <= ST_CONV;
                        wr_ptr   <= '0;
                        last_idx <= field_to_last(cfg_scan);
                        eoc      <= 1'b1;
                        osc_en   <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        if (wr_ptr == last_idx) begin
                            state  <= ST_READY;
                            eoc    <= 1'b0;
                            osc_en <= 1'b0;
                        end else begin
                            wr_ptr <= wr_ptr + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WPTR_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> (wr_ptr <= last_idx)); // R3
    AST_EOC_FALL_STOPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc) |-> (!osc_en && state == ST_READY)); // R4
    AST_EOC_RISE_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> $past(cfg_wr)); // R10
    AST_CONV_KEEPS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> (eoc && osc_en)); // R4

endmodule

// File: rtl/result_buffer.sv
// result_buffer: one register per scan slot, written at the slot chosen by
// the write pointer, read one bit at a time through a pointer and bit select.
// Assumes DEPTH is a power of two matching the pointer width.
module result_buffer #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [BIT_W-1:0]  bit_pos,
    output logic              rd_bit
);

    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Each slot captures the core's result when addressed, clears on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    // Bit-select read of the addressed slot
    assign rd_bit = slot[rd_ptr][bit_pos];

endmodule

// File: rtl/serial_shifter.sv
// serial_shifter: detects falling edges of the external serial clock and
// walks a bit position and read pointer over the stored results, MSB first.
// Assumes sclk is already synchronous to clk. Holds at the first bit of the
// first slot whenever readout is not enabled.
module serial_shifter #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sclk,
    input  logic [PTR_W-1:0] last_idx,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [BIT_W-1:0] bit_pos,
    output logic             drained
);

    localparam logic [BIT_W-1:0] MSB_POS = BIT_W'(DATA_W - 1);

    logic sclk_q;
    logic sclk_fall;

    // Previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_fall = sclk_q && !sclk;

    // Bit and slot stepping on each serial clock fall during readout
    always_ff @(posedge clk) begin
        if (!rst_n || !shift_en) begin
            rd_ptr  <= '0;
            bit_pos <= MSB_POS;
            drained <= 1'b0;
        end else if (sclk_fall && !drained) begin
            if (bit_pos == '0) begin
                bit_pos <= MSB_POS;
                if (rd_ptr == last_idx) drained <= 1'b1;
                else                    rd_ptr  <= rd_ptr + 1'b1;
            end else begin
                bit_pos <= bit_pos - 1'b1;
            end
        end
    end

    AST_HOLD_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !sclk_fall) |=> (!shift_en || ($stable(bit_pos) && $stable(rd_ptr)))); // R6
    AST_DRAIN_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drained) |-> (rd_ptr == last_idx && bit_pos == MSB_POS)); // R7

endmodule

// File: rtl/scan_result_sequencer.sv
// scan_result_sequencer: top of the scan back end. Requests conversions in
// channel order, buffers every result, drops eoc after the last one and then
// serialises the results MSB first on sclk falling edges.
// Assumes a stubbed core with a request/done/data handshake and an sclk level
// synchronous to clk.
module scan_result_sequencer
    import scan_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_scan,
    output logic              conv_req,
    output logic [PTR_W-1:0]  conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              osc_en,
    output logic              eoc,
    input  logic              sclk,
    output logic              dout
);

    seq_state_t       state;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] last_idx;
    logic             wr_en;
    logic [PTR_W-1:0] rd_ptr;
    logic [BIT_W-1:0] bit_pos;
    logic             drained;
    logic             rd_bit;
    logic             shift_en;

    scan_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_scan (cfg_scan),
        .conv_done(conv_done),
        .state    (state),
        .wr_ptr   (wr_ptr),
        .last_idx (last_idx),
        .wr_en    (wr_en),
        .eoc      (eoc),
        .osc_en   (osc_en)
    );

    result_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .BIT_W(BIT_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr),
        .wr_data(conv_data),
        .rd_ptr (rd_ptr),
        .bit_pos(bit_pos),
        .rd_bit (rd_bit)
    );

    serial_shifter #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .BIT_W(BIT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .sclk    (sclk),
        .last_idx(last_idx),
        .rd_ptr  (rd_ptr),
        .bit_pos (bit_pos),
        .drained (drained)
    );

    // Readout runs only once the scan has finished
    assign shift_en  = (state == ST_READY);
    assign conv_req  = (state == ST_CONV);
    assign conv_chan = wr_ptr;
    // Serial line carries buffered bits until drained, zero otherwise
    assign dout      = shift_en && !drained && rd_bit;

    AST_DOUT_QUIET_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> !dout); // R8
    AST_REQ_ONLY_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> eoc); // R3

endmodule

// File: tb/tb_scan_result_sequencer.sv
module tb_scan_result_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_scan = 2'd0;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = 16'h0;
    logic        osc_en;
    logic        eoc;
    logic        sclk = 1'b0;
    logic        dout;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_word [8];

    always #5 clk = ~clk;

    scan_result_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_scan(cfg_scan),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .osc_en(osc_en), .eoc(eoc), .sclk(sclk), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    task automatic sclk_pulse();
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(eoc == 1'b1 && osc_en == 1'b0 && conv_req == 1'b0 && dout == 1'b0,
              "R1 during reset", {eoc, osc_en, conv_req, dout}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(eoc == 1'b1 && osc_en == 1'b0 && conv_req == 1'b0 && dout == 1'b0,
              "R1 after reset", {eoc, osc_en, conv_req, dout}, 32'h8);
    endtask

    // Run one scan; collide drops sclk with the last done, inject writes cfg mid-scan
    task automatic run_scan(input logic [1:0] field, input logic [15:0] seed,
                            input bit collide, input bit inject, input string tag);
        int n;
        n = 1 << field;
        cfg_scan = field;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_scan = 2'd0;
        check(eoc && osc_en && conv_req && conv_chan == 3'd0 && !dout,
              {tag, " scan start"}, {eoc, osc_en, conv_req, conv_chan, dout}, 32'h70);
        for (int i = 0; i < n; i++) begin
            sclk_pulse();
            check(!dout && eoc, "R8 fall during scan", {eoc, dout}, 32'h2);
            if (inject && i == 1) begin
                cfg_scan = 2'd0;
                cfg_wr = 1'b1;
                @(negedge clk);
                cfg_wr = 1'b0;
            end
            check(conv_chan == 3'(i) && conv_req && eoc && osc_en,
                  "R3/R4/R9 channel step", {conv_chan, conv_req, eoc}, {3'(i), 2'b11});
            if (collide && i == n - 1) begin
                sclk = 1'b1;
                @(negedge clk);
                sclk = 1'b0;
            end
            exp_word[i] = seed ^ 16'(i * 16'h1357) ^ 16'(i << 12);
            conv_data = exp_word[i];
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            conv_data = 16'h0;
        end
        check(!eoc && !osc_en && !conv_req, "R4 eoc and osc fall after final done",
              {eoc, osc_en, conv_req}, 32'h0);
        check(dout == exp_word[0][15], "R5 first MSB at eoc fall", dout, exp_word[0][15]);
    endtask

    task automatic read_results(input int n);
        for (int r = 0; r < n; r++) begin
            logic [15:0] got;
            got = '0;
            for (int b = 15; b >= 0; b--) begin
                got[b] = dout;
                sclk_pulse();
            end
            check(got == exp_word[r], "R6 word in channel order", got, exp_word[r]);
        end
    endtask

    task automatic check_drained();
        for (int k = 0; k < 4; k++) begin
            check(dout == 1'b0 && eoc == 1'b0, "R7 zero after last bit", {eoc, dout}, 32'h0);
            sclk_pulse();
        end
    endtask

    initial begin
        @(negedge clk);
        test_reset();

        // Single channel, then two channels with sclk colliding with the last done
        run_scan(2'd0, 16'hA5C3, 1'b0, 1'b0, "R2 one channel");
        read_results(1);
        check_drained();

        run_scan(2'd1, 16'h8001, 1'b1, 1'b0, "R8 collide");
        read_results(2);
        check_drained();

        // Four channels with a config write mid-scan that must be ignored
        run_scan(2'd2, 16'hF00F, 1'b0, 1'b1, "R9 inject");
        read_results(4);
        check_drained();

        // Eight channels, abandon readout part-way and restart
        run_scan(2'd3, 16'h3C5A, 1'b1, 1'b0, "R2 eight channels");
        sclk_pulse();
        sclk_pulse();
        run_scan(2'd1, 16'h7E81, 1'b0, 1'b0, "R10 restart mid-readout");
        read_results(2);
        check_drained();

        // Reset in the middle of a ready buffer
        run_scan(2'd0, 16'hFFFF, 1'b0, 1'b0, "R2 before reset");
        test_reset();

        finish_run();
    end

endmodule